// File: doc/BRIEF.md
# Quadrature Commutating SSB Modulator Core

This block is a digital model of a four-phase switching modulator that produces single-sideband or keyed-carrier samples. Two signed audio streams arrive from the two legs of an external 90-degree phase splitter. They are captured on a valid strobe and routed onto I and Q by a sideband-select bit. Saturating negation then forms the inverted copies, which gives four phases of the audio spaced 90 degrees apart.

The block is clocked at four times the wanted RF frequency. A two-flip-flop twisted-ring counter produces two square waves in quadrature. The counter state is decoded into a two-bit select code. That code steps a 4:1 selector through I, Q, inverted I and inverted Q on successive clocks, and the selected sample is registered onto the output.

A change of sideband is applied only at the boundary between two four-clock commutation cycles. In carrier mode, a keyed constant level drives I and zero drives Q, and the audio legs are not used.

Top module: `qcm_top`

## Requirements
- R1: `quad_i` and `quad_q` are square waves with a period of 4 clocks. The pair (`quad_q`,`quad_i`) steps 00, 01, 11, 10 and then repeats, one step per clock, so `quad_q` is `quad_i` delayed by one clock.
- R2: `sel_code` advances by one, modulo 4, on every clock: 01, 10, 11, 00. Code 01 is the 0° phase and coincides with the quad state 00. Code 10 is 90°, code 11 is 180° and code 00 is 270°.
- R3: The selector maps `sel_code` to a signal as follows: 01 gives I, 10 gives Q, 11 gives inverted I and 00 gives inverted Q.
- R4: `rf_out` is registered. It shows the signal selected by the `sel_code` of the previous clock, which is one clock of fixed latency.
- R5: With the applied sideband at 0, the upper leg drives I and the lower leg drives Q. With the applied sideband at 1, the upper leg drives Q and the lower leg drives I.
- R6: `sb_sel` is sampled only in the clock where `sel_code` is 00. The new routing applies from the next clock, which is the clock with code 01. A change of `sb_sel` at any other time has no effect until that sampling point.
- R7: Negation is done in 16-bit two's complement and saturates. The value -32768 (0x8000) inverts to +32767 (0x7FFF). Any other value x inverts to -x.
- R8: `leg_upper` and `leg_lower` are captured on a clock where `smp_valid` is 1. The captured values are held while `smp_valid` is 0.
- R9: With `cw_mode` at 1, I is the parameter `CW_LEVEL` (default 24576) when `cw_key` is 1 and 0 when `cw_key` is 0. Q is 0 and the audio legs have no effect on `rf_out`.
- R10: A synchronous active-high `rst` clears both quad outputs, sets `sel_code` to 01, clears `rf_out` and both held samples, and sets the applied sideband to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Commutation clock, four times the RF frequency |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Capture strobe for both audio legs |
| leg_upper | input | 16 | Signed sample from the upper phase-splitter leg |
| leg_lower | input | 16 | Signed sample from the lower phase-splitter leg |
| sb_sel | input | 1 | Requested sideband; 0 sends the upper leg to I |
| cw_mode | input | 1 | 1 selects the keyed constant carrier in place of audio |
| cw_key | input | 1 | Key input in carrier mode; 1 means key down |
| rf_out | output | 16 | Registered commutated output sample |
| quad_i | output | 1 | In-phase square wave at one quarter of the clock rate |
| quad_q | output | 1 | Quadrature square wave, one clock behind `quad_i` |
| sel_code | output | 2 | Phase select code driving the selector |

## Verification
The bench pulses `smp_valid` in every phase of the commutation cycle. A design that captured samples only at cycle starts, or that ignored the strobe, would therefore output stale or drifting samples. It toggles `sb_sel` in the middle of cycles to catch a swap that takes effect at once and splits a cycle between the two routings. It also drives 0x8000 on both legs, where plain negation would leave the inverted phases at -32768 rather than +32767. In carrier mode it keys the level on and off while the legs keep changing, which exposes any leakage of audio onto Q, a wrong level, or a key that is not honoured.

// File: rtl/qcm_pkg.sv
package qcm_pkg;

  // Select codes driven onto the 4:1 selector
  typedef enum logic [1:0] {
    SEL_NQ = 2'b00,  // inverted Q, 270 deg
    SEL_I  = 2'b01,  // I, 0 deg
    SEL_Q  = 2'b10,  // Q, 90 deg
    SEL_NI = 2'b11   // inverted I, 180 deg
  } sel_e;

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/qcm_phase_counter.sv
module qcm_phase_counter (
  input  logic       clk,
  input  logic       rst,
  output logic       quad_i,
  output logic       quad_q,
  output logic [1:0] sel_code,
  output logic       cycle_last
);
  import qcm_pkg::*;

  logic ff0, ff1;
  logic nxt0, nxt1;
  logic [1:0] code_nxt;

  // Twisted ring: the first stage takes the inverse of the second stage
  assign nxt0 = ~ff1;
  assign nxt1 = ff0;

  // Decode of the next state: 00->01, 01->10, 11->11, 10->00
  assign code_nxt = {nxt0, ~(nxt0 ^ nxt1)};

  always_ff @(posedge clk) begin
    if (rst) begin
      ff0      <= 1'b0;
      ff1      <= 1'b0;
      sel_code <= SEL_I;
    end else begin
      ff0      <= nxt0;
      ff1      <= nxt1;
      sel_code <= code_nxt;
    end
  end

  assign quad_i     = ff0;
  assign quad_q     = ff1;
  assign cycle_last = (sel_code == SEL_NQ);

endmodule

// File: rtl/qcm_leg_router.sv
module qcm_leg_router #(
  parameter int DATA_W   = 16,
  parameter int CW_LEVEL = 24576
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] leg_upper,
  input  logic signed [DATA_W-1:0] leg_lower,
  input  logic                     sb_sel,
  input  logic                     cycle_last,
  input  logic                     cw_mode,
  input  logic                     cw_key,
  output logic signed [DATA_W-1:0] i_leg,
  output logic signed [DATA_W-1:0] q_leg,
  output logic                     sb_act
);

  localparam logic signed [DATA_W-1:0] CW_VAL = CW_LEVEL[DATA_W-1:0];

  logic signed [DATA_W-1:0] up_h, lo_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_h   <= '0;
      lo_h   <= '0;
      sb_act <= 1'b0;
    end else begin
      if (smp_valid) begin
        up_h <= leg_upper;
        lo_h <= leg_lower;
      end
      // Swap is applied only as a new commutation cycle begins
      if (cycle_last) sb_act <= sb_sel;
    end
  end

  always_comb begin
    if (cw_mode) begin
      i_leg = cw_key ? CW_VAL : '0;
      q_leg = '0;
    end else if (sb_act) begin
      i_leg = lo_h;
      q_leg = up_h;
    end else begin
      i_leg = up_h;
      q_leg = lo_h;
    end
  end

endmodule

// File: rtl/qcm_phase_select.sv
module qcm_phase_select #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] i_leg,
  input  logic signed [DATA_W-1:0] q_leg,
  input  logic [1:0]               sel_code,
  output logic signed [DATA_W-1:0] rf_out
);
  import qcm_pkg::*;

  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MAXV = ~MINV;

  logic signed [DATA_W-1:0] pos [NUM_LEGS];
  logic signed [DATA_W-1:0] neg [NUM_LEGS];
  logic signed [DATA_W-1:0] pick;

  assign pos[0] = i_leg;
  assign pos[1] = q_leg;

  // Saturating unity-gain inverter for each leg
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_inv
    assign neg[g] = (pos[g] == MINV) ? MAXV : -pos[g];
  end

  always_comb begin
    case (sel_e'(sel_code))
      SEL_I:   pick = pos[0];
      SEL_Q:   pick = pos[1];
      SEL_NI:  pick = neg[0];
      default: pick = neg[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rf_out <= '0;
    else     rf_out <= pick;
  end

endmodule

// File: rtl/qcm_top.sv
module qcm_top #(
  parameter int DATA_W   = 16,
  parameter int CW_LEVEL = 24576
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] leg_upper,
  input  logic signed [DATA_W-1:0] leg_lower,
  input  logic                     sb_sel,
  input  logic                     cw_mode,
  input  logic                     cw_key,
  output logic signed [DATA_W-1:0] rf_out,
  output logic                     quad_i,
  output logic                     quad_q,
  output logic [1:0]               sel_code
);

  logic                     cycle_last;
  logic                     sb_act;
  logic signed [DATA_W-1:0] i_leg, q_leg;

  qcm_phase_counter u_cnt (
    .clk        (clk),
    .rst        (rst),
    .quad_i     (quad_i),
    .quad_q     (quad_q),
    .sel_code   (sel_code),
    .cycle_last (cycle_last)
  );

  qcm_leg_router #(.DATA_W(DATA_W), .CW_LEVEL(CW_LEVEL)) u_route (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .leg_upper  (leg_upper),
    .leg_lower  (leg_lower),
    .sb_sel     (sb_sel),
    .cycle_last (cycle_last),
    .cw_mode    (cw_mode),
    .cw_key     (cw_key),
    .i_leg      (i_leg),
    .q_leg      (q_leg),
    .sb_act     (sb_act)
  );

  qcm_phase_select #(.DATA_W(DATA_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .i_leg    (i_leg),
    .q_leg    (q_leg),
    .sel_code (sel_code),
    .rf_out   (rf_out)
  );

endmodule

// File: rtl/qcm_checker.sv
module qcm_checker #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     quad_i,
  input logic                     quad_q,
  input logic [1:0]               sel_code,
  input logic signed [DATA_W-1:0] rf_out,
  input logic signed [DATA_W-1:0] i_leg,
  input logic signed [DATA_W-1:0] q_leg,
  input logic                     sb_act,
  input logic                     cw_mode
);

  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MAXV = ~MINV;

  AST_QUAD_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (quad_q == $past(quad_i))); // R1

  AST_QUAD_TWIST: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (quad_i == !$past(quad_q))); // R1

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sel_code == 2'($past(sel_code) + 2'd1))); // R2

  AST_OUT_I: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b01) |=> (rf_out == $past(i_leg))); // R4

  AST_OUT_Q: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b10) |=> (rf_out == $past(q_leg))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b11 && i_leg == MINV) |=> (rf_out == MAXV)); // R7

  AST_SB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sel_code != 2'b00) |=> (sb_act == $past(sb_act))); // R6

  AST_CW_Q_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cw_mode && sel_code == 2'b10) |=> (rf_out == '0)); // R9

endmodule

bind qcm_top qcm_checker #(.DATA_W(DATA_W)) u_qcm_chk (
  .clk      (clk),
  .rst      (rst),
  .quad_i   (quad_i),
  .quad_q   (quad_q),
  .sel_code (sel_code),
  .rf_out   (rf_out),
  .i_leg    (i_leg),
  .q_leg    (q_leg),
  .sb_act   (sb_act),
  .cw_mode  (cw_mode)
);

// File: tb/tb_qcm_top.sv
module tb_qcm_top;

  localparam int CLK_PERIOD = 10;
  localparam int CWL        = 24576;
  localparam int WATCHDOG   = 20000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_valid = 1'b0;
  logic signed [15:0] leg_upper = '0;
  logic signed [15:0] leg_lower = '0;
  logic               sb_sel = 1'b0;
  logic               cw_mode = 1'b0;
  logic               cw_key = 1'b0;
  logic signed [15:0] rf_out;
  logic               quad_i, quad_q;
  logic [1:0]         sel_code;

  int    checks = 0;
  int    fails  = 0;
  bit    armed  = 1'b0;
  bit    done   = 1'b0;
  string cur_tag = "R10";

  // Reference model state
  int                 mk = 0;
  logic signed [15:0] m_up = '0, m_lo = '0, m_out = '0;
  bit                 m_sb = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qcm_top #(.DATA_W(16), .CW_LEVEL(CWL)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .leg_upper(leg_upper), .leg_lower(leg_lower), .sb_sel(sb_sel),
    .cw_mode(cw_mode), .cw_key(cw_key),
    .rf_out(rf_out), .quad_i(quad_i), .quad_q(quad_q), .sel_code(sel_code)
  );

  function automatic logic signed [15:0] sneg(input logic signed [15:0] x);
    if (x == 16'sh8000) return 16'sh7FFF;
    return -x;
  endfunction

  function automatic logic signed [15:0] model_pick();
    logic signed [15:0] iv, qv;
    if (cw_mode) begin
      iv = cw_key ? 16'(CWL) : 16'sd0;
      qv = 16'sd0;
    end else begin
      iv = m_sb ? m_lo : m_up;
      qv = m_sb ? m_up : m_lo;
    end
    case (mk)
      0:       return iv;
      1:       return qv;
      2:       return sneg(iv);
      default: return sneg(qv);
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mk    <= 0;
      m_up  <= '0;
      m_lo  <= '0;
      m_sb  <= 1'b0;
      m_out <= '0;
    end else begin
      m_out <= model_pick();
      mk    <= (mk + 1) % 4;
      if (smp_valid) begin
        m_up <= leg_upper;
        m_lo <= leg_lower;
      end
      if (mk == 3) m_sb <= sb_sel;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R1", int'(quad_i), (mk == 1 || mk == 2) ? 1 : 0);
      chk("R1", int'(quad_q), (mk == 2 || mk == 3) ? 1 : 0);
      chk("R2", int'(sel_code), (mk + 1) % 4);
      chk(cur_tag, int'(rf_out), int'(m_out));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(int up, int lo);
    @(negedge clk);
    smp_valid = 1'b1;
    leg_upper = 16'(up);
    leg_lower = 16'(lo);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      summary();
      $finish;
    end
  end

  initial begin
    // R10: reset state
    @(posedge clk);
    armed = 1'b1;
    run(3);
    chk("R10", int'(rf_out), 0);
    chk("R10", int'(sel_code), 1);
    chk("R10", int'({quad_q, quad_i}), 0);
    rst = 1'b0;

    // R4: latency from select code to output
    cur_tag = "R4";
    load(1000, -2000);
    run(12);

    // R3: all four phases with distinct magnitudes
    cur_tag = "R3";
    load(-3100, 4700);
    run(12);

    // R8: strobes falling in every phase of the cycle
    cur_tag = "R8";
    for (int n = 0; n < 120; n++) begin
      @(negedge clk);
      smp_valid = (n % 3 == 0);
      leg_upper = 16'(n * 517 - 9000);
      leg_lower = 16'(7000 - n * 311);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    leg_upper = 16'sd123;
    leg_lower = -16'sd456;
    run(10);

    // R5: routing with the opposite sideband held steady
    cur_tag = "R5";
    load(2500, -1500);
    sb_sel = 1'b1;
    run(16);
    sb_sel = 1'b0;
    run(8);

    // R6: sideband requests changing mid cycle
    cur_tag = "R6";
    for (int n = 0; n < 48; n++) begin
      @(negedge clk);
      if (n % 3 == 0) sb_sel = ~sb_sel;
    end
    sb_sel = 1'b0;
    run(8);

    // R7: most negative sample on both legs
    cur_tag = "R7";
    load(-32768, -32768);
    run(12);
    load(-32767, 32767);
    run(8);

    // R9: keyed carrier, legs still changing
    cur_tag = "R9";
    cw_mode = 1'b1;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (n % 5 == 0) cw_key = ~cw_key;
      smp_valid = 1'b1;
      leg_upper = 16'(n * 97);
      leg_lower = 16'(-n * 53);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    cw_key = 1'b0;
    run(6);
    cw_mode = 1'b0;
    run(8);

    // R10: reset in the middle of a run
    cur_tag = "R10";
    sb_sel = 1'b1;
    run(6);
    rst = 1'b1;
    run(2);
    chk("R10", int'(rf_out), 0);
    chk("R10", int'(sel_code), 1);
    rst = 1'b0;
    run(8);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule